// File: doc/BRIEF.md
# Current ADC Register Front-End

This block is the byte-wide register slave of a current-measurement ADC. A host reaches it over a simple select/write/address/data bus with 8-bit offsets. Identification registers are read-only constants. The host programs the mode, the channel, the digital parameters, the settle delay and the averaging registers, then sets the enable bit and writes the request bit. After that it either polls the status register until the two low bits read binary 01 or waits for the level interrupt. Finally it reads the 16-bit result as two bytes.

The block contains a small conversion model. A request is accepted only while the block is enabled. The conversion state machine moves IDLE -> BUSY on an accepted request. It moves BUSY -> DONE after `CONV_CYCLES` clock edges, and at that edge it latches `sample_in` and raises the interrupt. It moves BUSY -> IDLE when the enable bit is written to zero. It moves DONE -> BUSY on a new accepted request.

A protected reset-control register sits behind a one-shot key gate with two states. LOCKED -> ARMED happens on a write of the key byte 0xA5 to offset 0xD0. ARMED -> ARMED happens on another key write. ARMED -> LOCKED happens on any other bus access, and that access is the only one allowed to change the protected register.

Top module: `cadc_regfront`

## Requirements
- R1: Offset 0x01 reads the `REVISION` parameter, 0x04 reads 8, 0x05 reads 3, and 0xF4 reads the `TRIM_BYTE` parameter (bit 7 sign, bits 6:0 magnitude).
- R2: After reset every writable register reads 0x00, the status register at 0x08 reads 0x00 and `eoc_irq` is low.
- R3: Offsets 0x40, 0x48, 0x50, 0x51 and 0x5A read back the full byte last written. Offsets 0x46 (enable) and 0x5B (averaging enable) store only bit 7, and their other bits read 0.
- R4: A write with bit 7 set to 0x52 while enable is set starts a conversion. Status bits [1:0] read 10 (request set, end-of-conversion clear) for `CONV_CYCLES` cycles after that write's clock edge, then read 01. Offset 0x52 reads bit 7 set while the conversion is pending.
- R5: A request written while enable is clear is ignored: status stays 0x00.
- R6: Writing enable to 0 during a conversion aborts it at that edge: status reads 0x00 and no interrupt follows.
- R7: `eoc_irq` rises at the same edge as end-of-conversion. It falls on a read of 0x60 or on the next accepted request, and it stays high on other accesses.
- R8: At end-of-conversion `sample_in` is latched. Offset 0x60 reads bits 7:0 and offset 0x61 reads bits 15:8, and the value holds until the next end-of-conversion.
- R9: A write to 0xDA takes effect only when the bus access just before it was a write of 0xA5 to 0xD0. Otherwise the register keeps its value. It reads back at 0xDA, and its bit 2 drives `follow_warm`.
- R10: The unlock is consumed by any bus access other than a correct key write, including reads. A key write with a wrong value leaves the gate locked.
- R11: Unmapped offsets read 0x00, and writes to read-only offsets (0x04, 0x08) change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current offset (combinational) |
| sample_in | input | 16 | Converter sample latched at end of conversion |
| eoc_irq | output | 1 | Level end-of-conversion interrupt |
| follow_warm | output | 1 | Bit 2 of the protected reset-control register |

## Verification
The bench builds the block with `CONV_CYCLES` = 8, `REVISION` = 2 and `TRIM_BYTE` = 0x85. The short conversion lets it probe the exact edge where status turns from 10 to 01, abort a conversion halfway through, and run many back-to-back conversions in little time. The non-default revision and a trim byte with the sign bit set show that the identification reads come from the parameters and are not hard-wired.

// File: rtl/cadc_pkg.sv
package cadc_pkg;
    localparam int AW = 8;
    localparam int DW = 8;
    localparam int RES_W = 16;

    localparam logic [AW-1:0] A_REV    = 8'h01;
    localparam logic [AW-1:0] A_TYPE   = 8'h04;
    localparam logic [AW-1:0] A_SUB    = 8'h05;
    localparam logic [AW-1:0] A_STAT   = 8'h08;
    localparam logic [AW-1:0] A_MODE   = 8'h40;
    localparam logic [AW-1:0] A_EN     = 8'h46;
    localparam logic [AW-1:0] A_CHAN   = 8'h48;
    localparam logic [AW-1:0] A_DIG    = 8'h50;
    localparam logic [AW-1:0] A_SETTLE = 8'h51;
    localparam logic [AW-1:0] A_REQ    = 8'h52;
    localparam logic [AW-1:0] A_AVGC   = 8'h5A;
    localparam logic [AW-1:0] A_AVGE   = 8'h5B;
    localparam logic [AW-1:0] A_RES_LO = 8'h60;
    localparam logic [AW-1:0] A_RES_HI = 8'h61;
    localparam logic [AW-1:0] A_KEY    = 8'hD0;
    localparam logic [AW-1:0] A_RST    = 8'hDA;
    localparam logic [AW-1:0] A_TRIM   = 8'hF4;

    localparam logic [DW-1:0] KEY_VAL  = 8'hA5;
    localparam logic [DW-1:0] TYPE_VAL = 8'h08;
    localparam logic [DW-1:0] SUB_VAL  = 8'h03;

    localparam int NPLAIN = 5;

    function automatic logic [AW-1:0] plain_addr(input int idx);
        case (idx)
            0:       plain_addr = A_MODE;
            1:       plain_addr = A_CHAN;
            2:       plain_addr = A_DIG;
            3:       plain_addr = A_SETTLE;
            default: plain_addr = A_AVGC;
        endcase
    endfunction

    typedef enum logic { UL_LOCKED, UL_ARMED } unlock_e;
    typedef enum logic [1:0] { CV_IDLE, CV_BUSY, CV_DONE } conv_e;
endpackage

// File: rtl/cadc_unlock.sv
module cadc_unlock
    import cadc_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          grant
);
    unlock_e state_q, state_d;
    logic    key_wr;

    assign key_wr = acc && wr && (addr == A_KEY) && (wdata == KEY_VAL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= UL_LOCKED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        grant   = 1'b0;
        unique case (state_q)
            UL_LOCKED: begin
                if (key_wr) state_d = UL_ARMED;
            end
            UL_ARMED: begin
                grant = 1'b1;
                if (acc) state_d = key_wr ? UL_ARMED : UL_LOCKED;
            end
        endcase
    end
endmodule

// File: rtl/cadc_conv.sv
module cadc_conv
    import cadc_pkg::*;
#(
    parameter int CONV_CYCLES = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             start,
    input  logic             abort,
    input  logic             ack_low,
    input  logic [RES_W-1:0] sample,
    output logic             busy,
    output logic             done,
    output logic             irq,
    output logic [RES_W-1:0] result
);
    localparam int CNT_W = (CONV_CYCLES > 2) ? $clog2(CONV_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CONV_CYCLES - 1);

    conv_e            state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             accept;
    logic             finish;

    assign accept = start && enable && !abort;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CV_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_d == CV_BUSY && state_q != CV_BUSY) cnt_q <= '0;
            else if (state_q == CV_BUSY)                  cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        finish  = 1'b0;
        unique case (state_q)
            CV_IDLE: begin
                if (accept) state_d = CV_BUSY;
            end
            CV_BUSY: begin
                if (abort) state_d = CV_IDLE;
                else if (cnt_q == CNT_LAST) begin
                    state_d = CV_DONE;
                    finish  = 1'b1;
                end
            end
            CV_DONE: begin
                if (accept) state_d = CV_BUSY;
            end
            default: state_d = CV_IDLE;
        endcase
    end

    always_comb begin
        busy = (state_q == CV_BUSY);
        done = (state_q == CV_DONE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq    <= 1'b0;
            result <= '0;
        end else if (finish) begin
            irq    <= 1'b1;
            result <= sample;
        end else if (ack_low || accept) begin
            irq    <= 1'b0;
        end
    end
endmodule

// File: rtl/cadc_regs.sv
module cadc_regs
    import cadc_pkg::*;
#(
    parameter logic [7:0] REVISION  = 8'h01,
    parameter logic [7:0] TRIM_BYTE = 8'h00
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc,
    input  logic             wr,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    wdata,
    input  logic             grant,
    input  logic             busy,
    input  logic             done,
    input  logic [RES_W-1:0] result,
    output logic             en,
    output logic             start,
    output logic             abort,
    output logic             ack_low,
    output logic [DW-1:0]    rstctl,
    output logic [DW-1:0]    rdata
);
    logic          wr_hit;
    logic          avg_en;
    logic [DW-1:0] plain_rd [NPLAIN];

    assign wr_hit  = acc && wr;
    assign start   = wr_hit && (addr == A_REQ) && wdata[7];
    assign abort   = wr_hit && (addr == A_EN) && !wdata[7];
    assign ack_low = acc && !wr && (addr == A_RES_LO);

    for (genvar g = 0; g < NPLAIN; g++) begin : g_plain
        logic [DW-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                               q <= '0;
            else if (wr_hit && addr == plain_addr(g)) q <= wdata;
        end
        assign plain_rd[g] = q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en     <= 1'b0;
            avg_en <= 1'b0;
            rstctl <= '0;
        end else if (wr_hit) begin
            if (addr == A_EN)            en     <= wdata[7];
            if (addr == A_AVGE)          avg_en <= wdata[7];
            if (addr == A_RST && grant)  rstctl <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            A_REV:    rdata = REVISION;
            A_TYPE:   rdata = TYPE_VAL;
            A_SUB:    rdata = SUB_VAL;
            A_STAT:   rdata = {6'b0, busy, done};
            A_EN:     rdata = {en, 7'b0};
            A_REQ:    rdata = {busy, 7'b0};
            A_AVGE:   rdata = {avg_en, 7'b0};
            A_RES_LO: rdata = result[7:0];
            A_RES_HI: rdata = result[15:8];
            A_RST:    rdata = rstctl;
            A_TRIM:   rdata = TRIM_BYTE;
            default: begin
                for (int i = 0; i < NPLAIN; i++)
                    if (addr == plain_addr(i)) rdata = plain_rd[i];
            end
        endcase
    end
endmodule

// File: rtl/cadc_regfront.sv
module cadc_regfront
    import cadc_pkg::*;
#(
    parameter int         CONV_CYCLES = 64,
    parameter logic [7:0] REVISION    = 8'h01,
    parameter logic [7:0] TRIM_BYTE   = 8'h00
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [7:0]  bus_addr,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    input  logic [15:0] sample_in,
    output logic        eoc_irq,
    output logic        follow_warm
);
    logic             grant_w;
    logic             en_w, start_w, abort_w, ack_w;
    logic             busy_w, done_w;
    logic [RES_W-1:0] result_w;
    logic [DW-1:0]    rstctl_w;

    cadc_unlock u_unlock (
        .clk   (clk),
        .rst_n (rst_n),
        .acc   (bus_sel),
        .wr    (bus_wr),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .grant (grant_w)
    );

    cadc_conv #(.CONV_CYCLES(CONV_CYCLES)) u_conv (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (en_w),
        .start   (start_w),
        .abort   (abort_w),
        .ack_low (ack_w),
        .sample  (sample_in),
        .busy    (busy_w),
        .done    (done_w),
        .irq     (eoc_irq),
        .result  (result_w)
    );

    cadc_regs #(.REVISION(REVISION), .TRIM_BYTE(TRIM_BYTE)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .acc     (bus_sel),
        .wr      (bus_wr),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .grant   (grant_w),
        .busy    (busy_w),
        .done    (done_w),
        .result  (result_w),
        .en      (en_w),
        .start   (start_w),
        .abort   (abort_w),
        .ack_low (ack_w),
        .rstctl  (rstctl_w),
        .rdata   (bus_rdata)
    );

    assign follow_warm = rstctl_w[2];
endmodule

// File: rtl/cadc_regfront_chk.sv
module cadc_regfront_chk
    import cadc_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       bus_sel,
    input logic       bus_wr,
    input logic [7:0] bus_addr,
    input logic [7:0] bus_wdata,
    input logic       en,
    input logic       busy,
    input logic       done,
    input logic       irq,
    input logic       grant,
    input logic       follow_warm
);
    p_req_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == A_REQ && !en && !busy) |=> !busy);

    p_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_sel && bus_wr && bus_addr == A_EN && !bus_wdata[7]) |=> (!busy && !done));

    p_irq_needs_eoc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> done);

    p_eoc_raises_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> irq);

    p_irq_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && bus_sel && !bus_wr && bus_addr == A_RES_LO) |=> !irq);

    p_protect_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == A_RST && !grant) |=> $stable(follow_warm));

    p_unlock_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && bus_sel && !(bus_wr && bus_addr == A_KEY && bus_wdata == KEY_VAL)) |=> !grant);
endmodule

bind cadc_regfront cadc_regfront_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .en          (en_w),
    .busy        (busy_w),
    .done        (done_w),
    .irq         (eoc_irq),
    .grant       (grant_w),
    .follow_warm (follow_warm)
);

// File: tb/test_cadc_regfront.sv
`timescale 1ns/1ps
module test_cadc_regfront;
    localparam int C = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bsel = 1'b0, bwr = 1'b0;
    logic [7:0]  baddr = '0, bwdata = '0;
    logic [7:0]  brdata;
    logic [15:0] sample = '0;
    logic        irq, fwarm;

    int n_run = 0, n_fail = 0;
    bit done_flag = 0;

    typedef struct { logic [7:0] exp; string tag; } exp_t;
    exp_t q[$];

    always #5 clk = ~clk;

    cadc_regfront #(.CONV_CYCLES(C), .REVISION(8'h02), .TRIM_BYTE(8'h85)) i_cadc_regfront (
        .clk(clk), .rst_n(rst_n), .bus_sel(bsel), .bus_wr(bwr), .bus_addr(baddr),
        .bus_wdata(bwdata), .bus_rdata(brdata), .sample_in(sample),
        .eoc_irq(irq), .follow_warm(fwarm)
    );

    // Monitor: pops the expected read data and compares.
    always @(negedge clk) begin
        #2;
        if (bsel && !bwr) begin
            exp_t e;
            e = q.pop_front();
            n_run++;
            if (brdata !== e.exp) begin
                n_fail++;
                $display("FAIL %s: addr %02h got %02h expected %02h", e.tag, baddr, brdata, e.exp);
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bsel = 1; bwr = 1; baddr = a; bwdata = d;
        @(posedge clk); #1;
        bsel = 0; bwr = 0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
        exp_t e;
        e.exp = exp; e.tag = tag;
        q.push_back(e);
        @(negedge clk);
        bsel = 1; bwr = 0; baddr = a;
        @(posedge clk); #1;
        bsel = 0;
    endtask

    task automatic chk_bit(input logic act, input logic exp, input string tag);
        @(negedge clk); #2;
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R2 reset state
        chk_bit(irq, 1'b0, "R2 irq");
        rd(8'h08, 8'h00, "R2 status");
        rd(8'h46, 8'h00, "R2 enable");
        rd(8'h40, 8'h00, "R2 mode");
        rd(8'hDA, 8'h00, "R2 rstctl");
        // R1 identification
        rd(8'h01, 8'h02, "R1 revision");
        rd(8'h04, 8'h08, "R1 type");
        rd(8'h05, 8'h03, "R1 subtype");
        rd(8'hF4, 8'h85, "R1 trim");
        // R3 readback
        wr(8'h40, 8'h09); rd(8'h40, 8'h09, "R3 mode");
        wr(8'h48, 8'h05); rd(8'h48, 8'h05, "R3 chan");
        wr(8'h50, 8'h0C); rd(8'h50, 8'h0C, "R3 dig");
        wr(8'h51, 8'h33); rd(8'h51, 8'h33, "R3 settle");
        wr(8'h5A, 8'h02); rd(8'h5A, 8'h02, "R3 avgctl");
        wr(8'h5B, 8'hFF); rd(8'h5B, 8'h80, "R3 avgen");
        // R11 unmapped and read-only
        rd(8'h30, 8'h00, "R11 unmapped");
        wr(8'h08, 8'hFF); rd(8'h08, 8'h00, "R11 status ro");
        wr(8'h04, 8'h55); rd(8'h04, 8'h08, "R11 type ro");
        // R5 request while disabled
        wr(8'h52, 8'h80);
        rd(8'h08, 8'h00, "R5 status");
        rd(8'h52, 8'h00, "R5 req");
        // R4 conversion timing
        sample = 16'hBEEF;
        wr(8'h46, 8'hFF); rd(8'h46, 8'h80, "R3 enable");
        wr(8'h52, 8'h80);
        repeat (C - 1) @(posedge clk);
        rd(8'h08, 8'h02, "R4 status busy last");
        rd(8'h08, 8'h01, "R4 status eoc");
        chk_bit(irq, 1'b1, "R7 irq set");
        // R8 result, R7 ack
        rd(8'h61, 8'hBE, "R8 result hi");
        chk_bit(irq, 1'b1, "R7 irq held");
        rd(8'h60, 8'hEF, "R8 result lo");
        chk_bit(irq, 1'b0, "R7 irq ack");
        sample = 16'h1234;
        rd(8'h60, 8'hEF, "R8 result held");
        // second conversion, R7 clear by new request
        wr(8'h52, 8'h80);
        rd(8'h52, 8'h80, "R4 req pending");
        repeat (C) @(posedge clk);
        rd(8'h08, 8'h01, "R4 eoc second");
        rd(8'h61, 8'h12, "R8 hi second");
        chk_bit(irq, 1'b1, "R7 irq second");
        wr(8'h52, 8'h80);
        chk_bit(irq, 1'b0, "R7 irq clear by request");
        rd(8'h08, 8'h02, "R4 restart busy");
        // R6 abort
        wr(8'h46, 8'h00);
        rd(8'h08, 8'h00, "R6 status aborted");
        repeat (C + 2) @(posedge clk);
        chk_bit(irq, 1'b0, "R6 no irq");
        rd(8'h08, 8'h00, "R6 status stays");
        // R9 protected register
        wr(8'hD0, 8'hA5); wr(8'hDA, 8'h04);
        rd(8'hDA, 8'h04, "R9 unlocked write");
        chk_bit(fwarm, 1'b1, "R9 follow_warm");
        wr(8'hDA, 8'hFF);
        rd(8'hDA, 8'h04, "R9 write without key");
        // R10 consumption
        wr(8'hD0, 8'hA5); rd(8'h01, 8'h02, "R10 intervening read");
        wr(8'hDA, 8'h00);
        rd(8'hDA, 8'h04, "R10 key consumed");
        wr(8'hD0, 8'h5A); wr(8'hDA, 8'h00);
        rd(8'hDA, 8'h04, "R10 wrong key");
        wr(8'hD0, 8'hA5); wr(8'hD0, 8'hA5); wr(8'hDA, 8'h00);
        rd(8'hDA, 8'h00, "R10 rearm");
        chk_bit(fwarm, 1'b0, "R9 follow_warm clear");
        repeat (3) @(posedge clk);
        finish_run();
    end
endmodule